// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Word Store

This block models the device side of a small serial nonvolatile memory: 128 words of 8 bits held in flip-flops. It has three pins. A shift clock, a chip-enable, and a bidirectional data line, which is split here into an input, an output and an output-enable. The pins are sampled on a fast system clock, and the block acts on the edges it detects in those samples.

While chip-enable is high the block is in input mode. Each rising shift clock moves the data-line level into a frame shifter, least significant bit first. When chip-enable falls, the number of bits taken and the last bit shifted in (the control bit) select the command:

- An 8-bit frame with control bit 0 is a read.
- An 8-bit frame with control bit 1 is an erase.
- A 16-bit frame with control bit 1 is a write.

The first shift clock after the fall executes the command. For a read, that clock loads the addressed word, and the bits then appear on the following falling clock edges. For a reprogram command, the data-line level sampled on that clock selects the kind of change. A busy timer then blocks further commands for a fixed number of system clocks.

Top module: `serial_nvm_emu`

## Requirements
- R1: After reset, `dio_oe` and `busy_o` are low and every word reads as `INIT_WORD` (default 8'hFF).
- R2: Bits are taken only on a rising shift clock while chip-enable is high. They enter least significant first, so the first bit of a read frame is address bit 0.
- R3: A read frame is seven address bits followed by a control bit of 0. On the first rising shift clock after chip-enable falls, the word is loaded. On each following falling shift clock edge, `dio_oe` is high and `dio_o` shows the next bit, starting with bit 0.
- R4: `dio_oe` goes low on the first system clock edge at which chip-enable is seen high.
- R5: During a read, the data-line input level has no effect on the bits shifted out.
- R6: An 8-bit frame with a control bit of 1 erases the addressed word to 8'hFF if the data line is 1 on the executing clock. If the data line is 0 on that clock, the word is left unchanged.
- R7: A 16-bit frame carries data bits 0 to 7, then address bits 0 to 6, then a control bit of 1. If the data line is 0 on the executing clock, the word becomes the old word ANDed with the data. If the data line is 1, the word becomes the data (erase followed by write).
- R8: A 16-bit frame whose control bit is 0 is discarded, and the memory is unchanged.
- R9: `busy_o` rises one system clock after a programming clock and stays high for `PROG_CLKS` system clocks. A command whose chip-enable fall occurs while busy is ignored.
- R10: A frame of any length other than 8 or 16 bits is ignored: no read output and no memory change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock pin |
| ce_i | input | 1 | Chip-enable pin: high means input mode, low means execute |
| dio_i | input | 1 | Data line, input side |
| dio_o | output | 1 | Data line, output side |
| dio_oe | output | 1 | Data line output enable (low means high impedance) |
| busy_o | output | 1 | Programming in progress |

## Verification
The assertions take for granted that the three pins are synchronous to the system clock. They also assume that every pin level is held for at least two system clocks, so that a shift clock edge and a chip-enable edge never fall in the same sample. Chip-enable is assumed high through reset. The bench changes one pin at a time on the falling system clock edge and holds each level for two cycles. It never moves the shift clock and chip-enable together. A programming run in the bench is long enough that a whole second frame fits inside the busy window.

// File: rtl/snvm_pkg.sv
package snvm_pkg;
  localparam int ADDR_W    = 7;
  localparam int WORD_W    = 8;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SHORT_LEN = ADDR_W + 1;
  localparam int LONG_LEN  = WORD_W + ADDR_W + 1;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_ERASE, OP_WRITE} snvm_op_e;

  typedef struct packed {
    snvm_op_e            op;
    logic [ADDR_W-1:0]   addr;
    logic [WORD_W-1:0]   data;
  } snvm_cmd_t;

  // Frame length and trailing control bit pick the command.
  function automatic snvm_cmd_t decode_frame(input logic [CNT_W-1:0] nbits,
                                             input logic [LONG_LEN-1:0] sr,
                                             input logic busy);
    snvm_cmd_t c;
    logic      cb;
    cb     = sr[LONG_LEN-1];
    c.addr = sr[LONG_LEN-2 -: ADDR_W];
    c.data = sr[WORD_W-1:0];
    c.op   = OP_NONE;
    if (!busy) begin
      if (nbits == CNT_W'(SHORT_LEN))                c.op = cb ? OP_ERASE : OP_READ;
      else if (nbits == CNT_W'(LONG_LEN) && cb)      c.op = OP_WRITE;
    end
    return c;
  endfunction

  // New word content for a programming clock.
  function automatic logic [WORD_W-1:0] prog_value(input snvm_op_e op,
                                                   input logic level,
                                                   input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] data);
    if (op == OP_ERASE) return '1;
    if (level)          return data;
    return old & data;
  endfunction
endpackage

// File: rtl/snvm_pin_edges.sv
module snvm_pin_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic ce_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ce_rise,
  output logic ce_fall
);
  logic sclk_q;
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ce_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      ce_q   <= ce_i;
    end
  end

  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign ce_rise   = ce_i & ~ce_q;
  assign ce_fall   = ~ce_i & ce_q;
endmodule

// File: rtl/snvm_frame_shift.sv
module snvm_frame_shift
  import snvm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic                dio_i,
  input  logic                sclk_rise,
  input  logic                ce_rise,
  output logic [LONG_LEN-1:0] sr_o,
  output logic [CNT_W-1:0]    nbits_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_LEN + 1);

  logic             take_bit;
  logic [CNT_W-1:0] cnt_base;

  assign take_bit = ce_i & sclk_rise;
  assign cnt_base = ce_rise ? '0 : nbits_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o    <= '0;
      nbits_o <= '0;
    end else if (take_bit) begin
      sr_o    <= {dio_i, sr_o[LONG_LEN-1:1]};
      nbits_o <= (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + CNT_W'(1);
    end else begin
      nbits_o <= cnt_base;
    end
  end

  a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    nbits_o <= CNT_MAX);
  a_r2_frozen_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(sr_o));
endmodule

// File: rtl/snvm_word_array.sv
module snvm_word_array
  import snvm_pkg::*;
#(
  parameter int                PROG_CLKS = 64,
  parameter logic [WORD_W-1:0] INIT_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_fire,
  input  snvm_op_e          op,
  input  logic              level,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] rd_word,
  output logic              busy_o
);
  localparam int BW = $clog2(PROG_CLKS + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [BW-1:0]     bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_WORD;
      bcnt <= '0;
    end else if (prog_fire) begin
      mem[addr] <= prog_value(op, level, mem[addr], data);
      bcnt      <= BW'(PROG_CLKS);
    end else if (bcnt != '0) begin
      bcnt <= bcnt - BW'(1);
    end
  end

  assign rd_word = mem[addr];
  assign busy_o  = (bcnt != '0);

  a_r9_busy_follows_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> busy_o);
  a_r9_no_prog_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !prog_fire);
  a_r9_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(PROG_CLKS));
endmodule

// File: rtl/snvm_read_shift.sv
module snvm_read_shift
  import snvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              sclk_fall,
  output logic              dio_o,
  output logic              dio_oe
);
  logic [WORD_W-1:0] out_sr;
  logic              live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr <= '0;
      live   <= 1'b0;
      dio_o  <= 1'b0;
      dio_oe <= 1'b0;
    end else if (ce_i) begin
      live   <= 1'b0;
      dio_oe <= 1'b0;
    end else if (load) begin
      out_sr <= word;
      live   <= 1'b1;
    end else if (sclk_fall && live) begin
      dio_o  <= out_sr[0];
      out_sr <= out_sr >> 1;
      dio_oe <= 1'b1;
    end
  end

  a_r4_hiz_after_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i |=> !dio_oe);
  a_r3_drive_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> $past(sclk_fall));
endmodule

// File: rtl/serial_nvm_emu.sv
module serial_nvm_emu
  import snvm_pkg::*;
#(
  parameter int                PROG_CLKS = 64,
  parameter logic [WORD_W-1:0] INIT_WORD = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic ce_i,
  input  logic dio_i,
  output logic dio_o,
  output logic dio_oe,
  output logic busy_o
);
  logic                sclk_rise, sclk_fall, ce_rise, ce_fall;
  logic [LONG_LEN-1:0] sr;
  logic [CNT_W-1:0]    nbits;
  snvm_cmd_t           dec, cmd_q;
  logic                exec_clk, prog_fire, rd_load;
  logic [WORD_W-1:0]   rd_word;

  snvm_pin_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .ce_i(ce_i),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ce_rise(ce_rise), .ce_fall(ce_fall)
  );

  snvm_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .dio_i(dio_i),
    .sclk_rise(sclk_rise), .ce_rise(ce_rise), .sr_o(sr), .nbits_o(nbits)
  );

  assign dec = decode_frame(nbits, sr, busy_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q    <= '0;
    else if (ce_i)     cmd_q.op <= OP_NONE;
    else if (ce_fall)  cmd_q    <= dec;
    else if (exec_clk) cmd_q.op <= OP_NONE;
  end

  assign exec_clk  = sclk_rise & ~ce_i & (cmd_q.op != OP_NONE);
  assign prog_fire = exec_clk & ((cmd_q.op == OP_WRITE) | ((cmd_q.op == OP_ERASE) & dio_i));
  assign rd_load   = exec_clk & (cmd_q.op == OP_READ);

  snvm_word_array #(.PROG_CLKS(PROG_CLKS), .INIT_WORD(INIT_WORD)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_fire(prog_fire), .op(cmd_q.op), .level(dio_i),
    .addr(cmd_q.addr), .data(cmd_q.data), .rd_word(rd_word), .busy_o(busy_o)
  );

  snvm_read_shift u_read (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .load(rd_load), .word(rd_word),
    .sclk_fall(sclk_fall), .dio_o(dio_o), .dio_oe(dio_oe)
  );

  // R8, R10: frames of the wrong length or a long frame without the control bit are dropped
  a_r10_bad_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && nbits != CNT_W'(SHORT_LEN) && !(nbits == CNT_W'(LONG_LEN) && sr[LONG_LEN-1]))
      |=> cmd_q.op == OP_NONE);
  a_r6_one_exec_per_enable: assert property (@(posedge clk) disable iff (!rst_n)
    exec_clk |=> cmd_q.op == OP_NONE);
endmodule

// File: tb/sim_serial_nvm_emu.sv
module sim_serial_nvm_emu;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, ce = 1'b1, dio = 1'b0;
  logic dio_o, dio_oe, busy_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_nvm_emu #(.PROG_CLKS(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ce_i(ce), .dio_i(dio),
    .dio_o(dio_o), .dio_oe(dio_oe), .busy_o(busy_o)
  );

  // ---------------- behavioural reference model ----------------
  bit q[$];
  int m_op, m_addr, m_data, m_out, m_busy;
  int m_mem [128];
  bit m_live, m_oe, m_do, m_sq, m_cq;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_op = 0; m_addr = 0; m_data = 0; m_out = 0; m_busy = 0;
      for (int i = 0; i < 128; i++) m_mem[i] = 255;
      m_live = 0; m_oe = 0; m_do = 0; m_sq = 0; m_cq = 1;
    end else begin
      bit rise, fall, cfall, crise, fired;
      int nb;
      rise = sclk && !m_sq; fall = !sclk && m_sq;
      cfall = m_cq && !ce;  crise = !m_cq && ce;
      fired = 0;
      nb = (m_busy > 0) ? m_busy - 1 : 0;
      if (crise) q.delete();
      if (ce && rise) q.push_back(dio);
      if (!ce && rise && m_op != 0) begin
        if (m_op == 1) begin m_out = m_mem[m_addr]; m_live = 1; end
        else if (m_op == 2) begin
          if (dio) begin m_mem[m_addr] = 255; fired = 1; end
        end else begin
          m_mem[m_addr] = dio ? m_data : (m_mem[m_addr] & m_data);
          fired = 1;
        end
        m_op = 0;
      end
      if (ce) begin m_oe = 0; m_live = 0; end
      else if (fall && m_live) begin m_do = m_out[0]; m_out = m_out >> 1; m_oe = 1; end
      if (ce) m_op = 0;
      else if (cfall && m_busy == 0) begin
        if (q.size() == 8) begin
          m_addr = 0;
          for (int k = 0; k < 7; k++) m_addr += int'(q[k]) << k;
          m_op = q[7] ? 2 : 1;
        end else if (q.size() == 16 && q[15]) begin
          m_data = 0; m_addr = 0;
          for (int k = 0; k < 8; k++) m_data += int'(q[k]) << k;
          for (int k = 0; k < 7; k++) m_addr += int'(q[8+k]) << k;
          m_op = 3;
        end
      end
      m_busy = fired ? PROG : nb;
      m_sq = sclk; m_cq = ce;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(dio_oe === m_oe, "R3/R4 oe", int'(dio_oe), int'(m_oe));
      if (m_oe) check(dio_o === m_do, "R3/R5 data", int'(dio_o), int'(m_do));
      check(busy_o === (m_busy != 0), "R9 busy", int'(busy_o), int'(m_busy != 0));
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold2(); repeat (2) @(negedge clk); endtask

  task automatic pulse(input logic lvl);
    @(negedge clk) dio = lvl; hold2();
    sclk = 1'b1; hold2();
    sclk = 1'b0; hold2();
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) pulse(v[i]);
  endtask

  task automatic enable_low(); @(negedge clk) ce = 1'b0; hold2(); endtask
  task automatic enable_high(); @(negedge clk) ce = 1'b1; hold2(); endtask

  task automatic read_word(input int addr, output logic [7:0] got, output bit oe_ok);
    send_bits({8'h00, 1'b0, 7'(addr)}, 8);
    enable_low();
    oe_ok = 1;
    pulse(1'b1);                 // load clock, data line level irrelevant
    got[0] = dio_o; if (dio_oe !== 1'b1) oe_ok = 0;
    for (int i = 1; i < 8; i++) begin
      pulse(logic'(i % 2));      // R5: toggle data line while reading
      got[i] = dio_o; if (dio_oe !== 1'b1) oe_ok = 0;
    end
    enable_high();
    check(dio_oe === 1'b0, "R4 hiz after ce high", int'(dio_oe), 0);
  endtask

  task automatic expect_word(input int addr, input int exp, input string req);
    logic [7:0] got; bit oe_ok;
    read_word(addr, got, oe_ok);
    check(oe_ok, req, int'(oe_ok), 1);
    check(got == 8'(exp), req, int'(got), exp);
  endtask

  task automatic prog_long(input int addr, input int data, input logic cb, input logic lvl);
    send_bits({cb, 7'(addr), 8'(data)}, 16);
    enable_low(); pulse(lvl); enable_high();
  endtask

  task automatic prog_short(input int addr, input logic lvl);
    send_bits({8'h00, 1'b1, 7'(addr)}, 8);
    enable_low(); pulse(lvl); enable_high();
  endtask

  task automatic wait_idle(); while (busy_o) @(negedge clk); endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dio_oe === 1'b0, "R1 reset oe", int'(dio_oe), 0);
    check(busy_o === 1'b0, "R1 reset busy", int'(busy_o), 0);
    expect_word(5, 'hFF, "R1 erased after reset");

    prog_long(3, 'h5A, 1'b1, 1'b1);
    check(busy_o === 1'b1, "R9 busy after prog", int'(busy_o), 1);
    wait_idle();
    expect_word(3, 'h5A, "R7 erase-and-write");

    prog_long(3, 'h0F, 1'b1, 1'b0); wait_idle();
    expect_word(3, 'h0A, "R7 write ANDs");

    prog_short(3, 1'b0); wait_idle();
    expect_word(3, 'h0A, "R6 erase with line low no change");
    prog_short(3, 1'b1); wait_idle();
    expect_word(3, 'hFF, "R6 erase");

    prog_long(127, 'h3C, 1'b1, 1'b1); wait_idle();
    expect_word(127, 'h3C, "R7 top address");
    expect_word(0, 'hFF, "R7 other word untouched");

    prog_long(1, 'h81, 1'b1, 1'b1); wait_idle();
    expect_word(1, 'h81, "R2 lsb first addr 1");
    expect_word(64, 'hFF, "R2 addr 64 untouched");

    prog_long(9, 'h00, 1'b0, 1'b1); wait_idle();
    expect_word(9, 'hFF, "R8 long frame cb0 dropped");

    // R10: 12-bit frame, then clocks while enabled
    begin
      bit quiet = 1;
      send_bits(16'h0C05, 12);
      enable_low();
      for (int i = 0; i < 8; i++) begin pulse(1'b1); if (dio_oe !== 1'b0) quiet = 0; end
      enable_high();
      check(quiet, "R10 12-bit frame no output", int'(quiet), 1);
      expect_word(5, 'hFF, "R10 12-bit frame no change");
    end

    // R9: second command while busy is ignored
    prog_long(20, 'h11, 1'b1, 1'b1);
    send_bits({1'b1, 7'd21, 8'h22}, 16);
    check(busy_o === 1'b1, "R9 still busy at second command", int'(busy_o), 1);
    enable_low(); pulse(1'b1); enable_high();
    wait_idle();
    expect_word(21, 'hFF, "R9 command during busy ignored");
    expect_word(20, 'h11, "R9 first command applied");

    finish_run();
  end
endmodule